// File: doc/BRIEF.md
# Conditional Add-or-Copy Register Datapath

This block holds two registers of equal width. The accumulator register is loaded only while a timing strobe is high. A control bit chooses what it loads: either its own value plus the operand register, or a plain copy of the operand register. The operand register has its own load enable and data input, so it can be set from outside independently of the strobe. An adder always forms the sum of the two register contents, with its carry-in tied low. A row of two-input multiplexers, steered by the control bit, selects between that sum and the operand for the accumulator's input.

The strobe alone drives the accumulator's load line. Both transfers need the load, so the two product terms of the control function merge into the strobe itself. The control bit only steers the multiplexer. The carry-out of the adder is brought out as a flag for the current register contents. A parameter selects between an explicit ripple-carry adder and an inferred one.

Top module: `addxfer_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both `acc_q` and `b_q` to zero.
- R2: With `t_strobe`=1 and `sel_add`=1 at a rising edge, `acc_q` becomes (`acc_q` + `b_q`) modulo 2^WIDTH.
- R3: With `t_strobe`=1 and `sel_add`=0 at a rising edge, `acc_q` becomes `b_q`.
- R4: With `t_strobe`=0 at a rising edge, `acc_q` keeps its value whatever `sel_add` is.
- R5: With `b_load`=1 at a rising edge, `b_q` becomes `b_din`; with `b_load`=0, `b_q` keeps its value.
- R6: `carry_out` is combinationally bit WIDTH of the (WIDTH+1)-bit sum `acc_q` + `b_q`, with carry-in zero.
- R7: When `b_load` and `t_strobe` are both high at the same edge, the accumulator uses the operand value from before that edge.
- R8: Reset takes priority: with `rst` high, both registers clear even when `t_strobe` and `b_load` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| t_strobe | input | 1 | Timing strobe; load enable of the accumulator |
| sel_add | input | 1 | 1 selects sum, 0 selects copy of operand |
| b_load | input | 1 | Load enable of the operand register |
| b_din | input | WIDTH | Data for the operand register |
| acc_q | output | WIDTH | Accumulator contents |
| b_q | output | WIDTH | Operand register contents |
| carry_out | output | 1 | Adder carry-out for the current contents |

## Verification
The operand register load and the accumulator transfer can fall on the same clock edge. That edge then both reads and writes the operand. The bench provokes this with directed cases in both sum and copy mode, and random stimulus raises `b_load` and `t_strobe` together often. It judges the result against a model that computes the accumulator from the operand value held before the edge, then checks that the operand took the new input. Reset asserted together with both loads is also driven, and both registers must come out zero.

// File: rtl/addxfer_pkg.sv
package addxfer_pkg;
   typedef enum logic {
      PICK_COPY = 1'b0,
      PICK_SUM  = 1'b1
   } pick_e;

   localparam int ADDER_RIPPLE   = 0;
   localparam int ADDER_INFERRED = 1;
endpackage

// File: rtl/addxfer_adder.sv
module addxfer_adder #(
   parameter int WIDTH = 4,
   parameter int STYLE = addxfer_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   generate
      if (STYLE == addxfer_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = op_a[i] ^ op_b[i] ^ chain[i];
            assign chain[i+1] = (op_a[i] & op_b[i]) | (chain[i] & (op_a[i] ^ op_b[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_inferred
         logic [WIDTH:0] wide;
         assign wide = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/addxfer_mux2.sv
module addxfer_mux2 #(
   parameter int WIDTH = 4
) (
   input  addxfer_pkg::pick_e pick,
   input  logic [WIDTH-1:0]   in_copy,
   input  logic [WIDTH-1:0]   in_sum,
   output logic [WIDTH-1:0]   y
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         assign y[i] = (pick == addxfer_pkg::PICK_SUM) ? in_sum[i] : in_copy[i];
      end
   endgenerate
endmodule

// File: rtl/addxfer_reg.sv
module addxfer_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ld)
         q <= d;
   end
endmodule

// File: rtl/addxfer_datapath.sv
module addxfer_datapath #(
   parameter int WIDTH       = 4,
   parameter int ADDER_STYLE = addxfer_pkg::ADDER_RIPPLE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             t_strobe,
   input  logic             sel_add,
   input  logic             b_load,
   input  logic [WIDTH-1:0] b_din,
   output logic [WIDTH-1:0] acc_q,
   output logic [WIDTH-1:0] b_q,
   output logic             carry_out
);
   import addxfer_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("addxfer_datapath: WIDTH must be at least 1");
      end
      if (ADDER_STYLE != ADDER_RIPPLE && ADDER_STYLE != ADDER_INFERRED) begin : g_bad_style
         $error("addxfer_datapath: unknown ADDER_STYLE");
      end
   endgenerate

   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] acc_next;
   pick_e            pick;

   // Both product terms of the load function collapse to the strobe.
   assign pick = pick_e'(sel_add);

   addxfer_reg #(.WIDTH(WIDTH)) u_breg (
      .clk (clk),
      .rst (rst),
      .ld  (b_load),
      .d   (b_din),
      .q   (b_q)
   );

   addxfer_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .op_a (acc_q),
      .op_b (b_q),
      .cin  (1'b0),
      .sum  (sum_w),
      .cout (carry_out)
   );

   addxfer_mux2 #(.WIDTH(WIDTH)) u_mux (
      .pick    (pick),
      .in_copy (b_q),
      .in_sum  (sum_w),
      .y       (acc_next)
   );

   addxfer_reg #(.WIDTH(WIDTH)) u_acc (
      .clk (clk),
      .rst (rst),
      .ld  (t_strobe),
      .d   (acc_next),
      .q   (acc_q)
   );
endmodule

// File: rtl/addxfer_checker.sv
module addxfer_checker #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst,
   input logic         t_strobe,
   input logic         sel_add,
   input logic         b_load,
   input logic [W-1:0] b_din,
   input logic [W-1:0] acc_q,
   input logic [W-1:0] b_q,
   input logic         carry_out
);
   logic         rst_seen = 1'b0;
   logic [W:0]   wide_sum;

   assign wide_sum = {1'b0, acc_q} + {1'b0, b_q};

   always_ff @(posedge clk) rst_seen <= rst;

   always @(negedge clk) begin
      if (rst_seen) begin
         AST_RESET_CLEARS: assert (acc_q == '0 && b_q == '0); // R1
      end
   end

   AST_SUM_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (t_strobe && sel_add) |=> acc_q == $past(acc_q) + $past(b_q)); // R2

   AST_COPY_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (t_strobe && !sel_add) |=> acc_q == $past(b_q)); // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !t_strobe |=> $stable(acc_q)); // R4

   AST_OPERAND_LOAD: assert property (@(posedge clk) disable iff (rst)
      b_load |=> b_q == $past(b_din)); // R5

   AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (rst)
      !b_load |=> $stable(b_q)); // R5

   AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
      carry_out == wide_sum[W]); // R6
endmodule

bind addxfer_datapath addxfer_checker #(.W(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .t_strobe  (t_strobe),
   .sel_add   (sel_add),
   .b_load    (b_load),
   .b_din     (b_din),
   .acc_q     (acc_q),
   .b_q       (b_q),
   .carry_out (carry_out)
);

// File: tb/addxfer_datapath_test.sv
module addxfer_datapath_test;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         t_strobe = 1'b0;
   logic         sel_add = 1'b0;
   logic         b_load = 1'b0;
   logic [W-1:0] b_din = '0;
   logic [W-1:0] acc_q;
   logic [W-1:0] b_q;
   logic         carry_out;

   int runs = 0;
   int fails = 0;
   bit done = 0;
   logic [W-1:0] m_acc = '0;
   logic [W-1:0] m_b = '0;

   always #2 clk = ~clk;

   addxfer_datapath #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .t_strobe(t_strobe), .sel_add(sel_add),
      .b_load(b_load), .b_din(b_din), .acc_q(acc_q), .b_q(b_q),
      .carry_out(carry_out)
   );

   function automatic logic [W-1:0] next_acc(logic t, logic x, logic [W-1:0] a, logic [W-1:0] b);
      if (!t) return a;
      return x ? W'(a + b) : b;
   endfunction

   function automatic logic model_carry(logic [W-1:0] a, logic [W-1:0] b);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[W];
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One clock: drive at falling edge, compare just after the rising edge.
   task automatic step(logic r, logic t, logic x, logic bl, logic [W-1:0] bd,
                       string acc_req, string b_req);
      @(negedge clk);
      rst = r; t_strobe = t; sel_add = x; b_load = bl; b_din = bd;
      chk("R6 carry", 8'(carry_out), 8'(model_carry(m_acc, m_b)));
      @(posedge clk);
      if (r) begin
         m_acc = '0; m_b = '0;
      end else begin
         m_acc = next_acc(t, x, m_acc, m_b);
         if (bl) m_b = bd;
      end
      #1;
      chk(acc_req, 8'(acc_q), 8'(m_acc));
      chk(b_req, 8'(b_q), 8'(m_b));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      step(1, 0, 0, 0, '0, "R1 acc reset", "R1 b reset");
      // R5 load operand, R3 copy
      step(0, 0, 0, 1, 4'h7, "R4 acc hold", "R5 b load");
      step(0, 1, 0, 0, 4'h0, "R3 copy", "R5 b hold");
      // R2 and R6 wrap: 7+7=14, then 14+7 wraps to 5 with carry
      step(0, 1, 1, 0, 4'h0, "R2 sum", "R5 b hold");
      step(0, 1, 1, 0, 4'h0, "R2 sum wrap", "R5 b hold");
      // R4: strobe low, sel toggled
      step(0, 0, 1, 0, 4'h0, "R4 hold x=1", "R5 b hold");
      step(0, 0, 0, 0, 4'h0, "R4 hold x=0", "R5 b hold");
      // R7: simultaneous load, copy and sum use old operand
      step(0, 1, 0, 1, 4'hF, "R7 copy old b", "R7 b new");
      step(0, 1, 1, 1, 4'h1, "R7 sum old b", "R7 b new");
      step(0, 1, 1, 0, 4'h0, "R2 sum", "R5 b hold");
      // R8: reset beats both loads
      step(1, 1, 1, 1, 4'hA, "R8 acc reset prio", "R8 b reset prio");
      // F + 1 boundary
      step(0, 0, 0, 1, 4'hF, "R4 acc hold", "R5 b load");
      step(0, 1, 0, 1, 4'h1, "R7 copy old b", "R7 b new");
      step(0, 1, 1, 0, 4'h0, "R2 F+1 wrap", "R5 b hold");
      step(0, 0, 0, 0, 4'h0, "R4 hold", "R5 b hold");
      for (int i = 0; i < 400; i++) begin
         logic r, t, x, bl;
         logic [W-1:0] bd;
         r  = ($urandom % 40) == 0;
         t  = ($urandom % 4) != 0;
         x  = $urandom % 2;
         bl = ($urandom % 2) == 0;
         bd = W'($urandom);
         step(r, t, x, bl, bd,
              r ? "R8 acc" : (!t ? "R4 acc" : (x ? "R2 acc" : "R3 acc")),
              r ? "R8 b" : (bl && t ? "R7 b" : "R5 b"));
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule